// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Source and Enable Register

This block collects three interrupt conditions of a data-acquisition card into one 8-bit register and raises a single interrupt request. Two of the conditions (an external trigger input and the output of counter channel 1) are edge sources: a rising edge, seen while the matching enable is set, sets a sticky latch. The third condition (the DAC FIFO request) is a level source: its status bit follows the sampled condition while enabled and carries no memory.

Software reads the register to see what is pending and writes it to set the enable mask. Writing a 0 to an enable bit clears that source's latch. This is also how an edge is acknowledged. Software writes the enables with the pending bits masked out, then writes the enables again to re-arm the sources. The interrupt request is a registered OR of all pending status bits. The read path is plain combinational status with no side effect, and the write strobe has no back-pressure.

Top module: `irq_source_reg`

## Requirements
- R1: After reset the enable mask is 0, the read value is 0x00 and `irq` is 0.
- R2: Status positions are: bit 0 = external edge, bit 2 = FIFO level, bit 5 = counter-1 edge. Bits 1, 3 and 4 and bits 7:6 always read 0.
- R3: A cycle with `wr_en` high stores `wr_data` as the enable mask at that clock edge. Writing 0x00 drops every status bit on the same edge.
- R4: A 0-to-1 transition on `src_ext` sets status bit 0 two clock edges after the input is first high, provided enable bit 0 is 1. The bit then stays set after the input falls.
- R5: A 0-to-1 transition on `src_cnt1` sets status bit 5 with the same timing and persistence as R4, under enable bit 5.
- R6: A rising edge that occurs while its enable bit is 0 is discarded. Setting the enable afterwards does not make the bit pending.
- R7: A write whose enable bit is 0 clears that edge latch. A later rewrite with the bit set re-arms it but does not re-latch an input that is still held high, because only a new 0-to-1 transition sets it.
- R8: Status bit 2 equals `src_fifo` sampled one clock edge earlier ANDed with enable bit 2, with no latching.
- R9: `irq` is high in the cycle after any status bit reads 1, and low in the cycle after all status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the enable mask |
| wr_data | input | 8 | New enable mask |
| rd_data | output | 8 | Pending status, reserved bits zero |
| src_ext | input | 1 | External trigger (edge source) |
| src_fifo | input | 1 | DAC FIFO request (level source) |
| src_cnt1 | input | 1 | Counter channel 1 output (edge source) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register, six status positions, edge sources at 0 and 5, and the level source at 2. These defaults place the reserved positions between used ones and the unused upper bits above them, so a random mix of enables and inputs shows any leak into positions 1, 3, 4, 6 or 7. Directed steps cover the held-high input across an acknowledge, and an edge that arrives while its source is disabled.

// File: rtl/irq_source_pkg.sv
package irq_source_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned STAT_W = 6;
  localparam int unsigned POS_EXT  = 0;
  localparam int unsigned POS_FIFO = 2;
  localparam int unsigned POS_CNT1 = 5;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_EDGE  = 2'd1,
    SRC_LEVEL = 2'd2
  } src_kind_e;

  function automatic src_kind_e kind_of(input int unsigned pos);
    if (pos == POS_EXT || pos == POS_CNT1) return SRC_EDGE;
    if (pos == POS_FIFO) return SRC_LEVEL;
    return SRC_NONE;
  endfunction
endpackage

// File: rtl/irq_edge_cell.sv
module irq_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic en_bit,
  input  logic wr_en,
  input  logic wr_bit,
  output logic pend
);
  logic smp_q, prev_q, lat_q;
  logic rise, keep;

  assign rise = smp_q & ~prev_q;
  assign keep = wr_en ? wr_bit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      smp_q  <= raw_in;
      prev_q <= smp_q;
      lat_q  <= keep & (lat_q | (rise & en_bit));
    end
  end

  assign pend = lat_q;

  // R6: a latch can only come up while its enable was set
  assert_edge_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> $past(en_bit));
  // R7: writing a zero enable clears the latch
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit) |=> !lat_q);
endmodule

// File: rtl/irq_level_cell.sv
module irq_level_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic en_bit,
  output logic pend
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= raw_in;
  end

  assign pend = cond_q & en_bit;

  // R8: level status needs the condition one edge earlier
  assert_level_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(raw_in));
endmodule

// File: rtl/irq_source_reg.sv
module irq_source_reg
  import irq_source_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned NSTAT  = STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              src_ext,
  input  logic              src_fifo,
  input  logic              src_cnt1,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - NSTAT;

  logic [DATA_W-1:0] en_q;
  logic [NSTAT-1:0]  raw_vec;
  logic [NSTAT-1:0]  stat;
  logic              irq_q;

  always_comb begin
    raw_vec = '0;
    raw_vec[POS_EXT]  = src_ext;
    raw_vec[POS_FIFO] = src_fifo;
    raw_vec[POS_CNT1] = src_cnt1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data;
  end

  for (genvar b = 0; b < NSTAT; b++) begin : g_src
    if (kind_of(b) == SRC_EDGE) begin : g_edge
      irq_edge_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_vec[b]),
        .en_bit (en_q[b]),
        .wr_en  (wr_en),
        .wr_bit (wr_data[b]),
        .pend   (stat[b])
      );
    end else if (kind_of(b) == SRC_LEVEL) begin : g_level
      irq_level_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_vec[b]),
        .en_bit (en_q[b]),
        .pend   (stat[b])
      );
    end else begin : g_rsvd
      assign stat[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat & en_q[NSTAT-1:0]);
  end

  assign rd_data = {{PAD_W{1'b0}}, stat};
  assign irq     = irq_q;

  // R2: reserved and upper positions never read as 1
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] == 1'b0) && (rd_data[3] == 1'b0) && (rd_data[4] == 1'b0)
    && (rd_data[DATA_W-1:NSTAT] == '0));
  // R3: a write of zero leaves nothing pending
  assert_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == '0) |=> (rd_data == '0));
  // R9: request follows pending status one edge later
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_data) |=> irq);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0) |=> !irq);
endmodule

// File: tb/test_irq_source_reg.sv
module test_irq_source_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       src_ext = 1'b0, src_fifo = 1'b0, src_cnt1 = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;

  localparam logic [5:0] EDGE_M = 6'b100001;
  localparam logic [5:0] LVL_M  = 6'b000100;

  logic [5:0] m_inq = '0, m_prev = '0, m_lat = '0;
  logic [7:0] m_en = '0;
  logic       m_irq = 1'b0;

  always #5 clk = ~clk;

  irq_source_reg i_irq_source_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_ext(src_ext), .src_fifo(src_fifo),
    .src_cnt1(src_cnt1), .irq(irq)
  );

  function automatic logic [7:0] m_status();
    return {2'b00, (m_lat & EDGE_M) | (m_inq & m_en[5:0] & LVL_M)};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d,
                      input logic e, input logic f, input logic c);
    logic [5:0] raw, rise, keep;
    @(negedge clk);
    wr_en = w; wr_data = d; src_ext = e; src_fifo = f; src_cnt1 = c;
    raw  = {c, 2'b00, f, 1'b0, e};
    rise = m_inq & ~m_prev;
    keep = w ? d[5:0] : 6'h3F;
    m_irq  = |m_status();
    m_lat  = (m_lat | (rise & m_en[5:0])) & keep & EDGE_M;
    m_prev = m_inq;
    m_inq  = raw;
    if (w) m_en = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic cmp_model(input string tag);
    check8({tag, " status"}, rd_data, m_status());
    check8("R9 irq", {7'd0, irq}, {7'd0, m_irq});
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    #1;
    check8("R1 reset read", rd_data, 8'h00);
    check8("R1 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check8("R1 after release", rd_data, 8'h00);

    // R3 enable write, R8 level source
    step(1, 8'h25, 0, 0, 0); cmp_model("R3");
    step(0, 8'h00, 0, 1, 0); check8("R8 level high", rd_data, 8'h04);
    step(0, 8'h00, 0, 1, 0); check8("R9 irq on level", {7'd0, irq}, 8'h01);
    step(0, 8'h00, 0, 0, 0); check8("R8 level drops", rd_data, 8'h00);

    // R4 external edge
    step(0, 8'h00, 1, 0, 0); check8("R4 one edge in", rd_data, 8'h00);
    step(0, 8'h00, 1, 0, 0); check8("R4 latched", rd_data, 8'h01);
    step(0, 8'h00, 0, 0, 0); check8("R4 holds after fall", rd_data, 8'h01);
    step(0, 8'h00, 1, 0, 0); cmp_model("R4");
    step(0, 8'h00, 1, 0, 0); cmp_model("R4");
    // R7 acknowledge with input still high
    step(1, 8'h24, 1, 0, 0); check8("R7 ack clears", rd_data, 8'h00);
    step(1, 8'h25, 1, 0, 0); check8("R7 rearm no relatch", rd_data, 8'h00);
    repeat (3) step(0, 8'h00, 1, 0, 0);
    check8("R7 held high stays clear", rd_data, 8'h00);
    check8("R9 irq low", {7'd0, irq}, 8'h00);

    // R5 counter edge
    step(0, 8'h00, 1, 0, 1);
    step(0, 8'h00, 1, 0, 0); check8("R5 counter latched", rd_data, 8'h20);
    step(0, 8'h00, 0, 0, 0); check8("R9 irq from counter", {7'd0, irq}, 8'h01);

    // R3 zero write
    step(1, 8'h00, 0, 1, 0); check8("R3 zero write", rd_data, 8'h00);
    step(0, 8'h00, 0, 1, 0); check8("R3 irq after zero", {7'd0, irq}, 8'h00);

    // R6 edge while disabled
    step(0, 8'h00, 1, 1, 1);
    step(0, 8'h00, 1, 1, 1);
    step(1, 8'h21, 1, 1, 1);
    step(0, 8'h00, 1, 1, 1); check8("R6 discarded edge", rd_data, 8'h00);

    // R2 reserved bits with everything enabled and active
    step(1, 8'hFF, 0, 1, 0);
    step(0, 8'h00, 1, 1, 1);
    step(0, 8'h00, 1, 1, 1);
    check8("R2 reserved zero", rd_data & 8'hDA, 8'h00);
    check8("R2 used bits", rd_data, 8'h25);

    // random mix against the model
    for (int i = 0; i < 600; i++) begin
      logic w;
      logic [7:0] d;
      w = ($urandom % 5) == 0;
      d = 8'($urandom);
      step(w, d, 1'($urandom), 1'($urandom), 1'($urandom));
      cmp_model("R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule